// File: doc/BRIEF.md
# Semi-unified instruction/data cache pair

Two direct-mapped arrays of equal size sit side by side. One is the first place an instruction fetch looks, and the other is the first place a load or store looks. When the first lookup misses, the request checks the other array at the same index before it goes to memory. The two lines at one index therefore act as a single two-entry set with a shared least-recently-used bit. Off-chip misses match those of a unified two-way cache of twice the size of one array. A hit in the requester's own array still has direct-mapped timing, and the two ports can both hit in the same cycle.

How much of the total capacity holds code and how much holds data is never fixed. A missing line goes into whichever way of its set was used least recently, whichever stream that way normally serves. Data stores are write-back. Both arrays share one line-wide memory port that uses a request/acknowledge handshake. A dirty victim is written out before the new line is fetched.

An address is a line address. Its low `IDX_W` bits select the set and the remaining upper bits are the tag. Way 0 is the instruction-side array and way 1 is the data-side array.

Top module: `semi_unified_cache`

## Requirements
- R1: An access that hits in its own array (instruction port in way 0, data port in way 1) is acknowledged combinationally in the cycle it is first presented, with that line's data.
- R2: An access that misses its own array but hits the other way of the set is acknowledged in its second cycle, causes no memory traffic, and leaves the line where it is, so a repeat access again takes two cycles.
- R3: The instruction and data ports can both hit their own arrays in the same cycle, and both are acknowledged in that cycle. If both hit the same set, the LRU bit ends up as the data port's update sets it.
- R4: When both ports are waiting on the other array in the same cycle, the data port is served first and the instruction port is acknowledged exactly one cycle later.
- R5: A miss in both ways fills one line into the way named by the set's LRU bit (0 = instruction array, 1 = data array). All LRU bits are 0 after reset. The access then completes from the filled line.
- R6: Every hit or fill marks the used way as most recently used. The sequence of off-chip fills equals that of a unified two-way LRU cache with 2·2^IDX_W lines.
- R7: If the victim line is valid and dirty, it is written to memory at address {victim tag, index} with its data before the fill is requested.
- R8: A data write that hits stores its data in the line and marks the line dirty, without any memory traffic. Instruction fetches never make a line dirty.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until a one-cycle `mem_ack`. A write transfer is followed directly by the fill read, and a fill read is followed by an idle cycle.
- R10: After reset every line is invalid, so the first access to any address goes to memory.
- R11: A read on either port returns the most recent value written to that address, whichever array holds the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Instruction fetch request, held until if_ack |
| if_addr | input | ADDR_W | Instruction line address |
| if_ack | output | 1 | Fetch completes this cycle |
| if_rdata | output | DATA_W | Fetched line, valid with if_ack |
| d_req | input | 1 | Data request, held until d_ack |
| d_we | input | 1 | 1 = store, 0 = load |
| d_addr | input | ADDR_W | Data line address |
| d_wdata | input | DATA_W | Store data |
| d_ack | output | 1 | Data access completes this cycle |
| d_rdata | output | DATA_W | Loaded line, valid with d_ack on a load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = fill read |
| mem_addr | output | ADDR_W | Memory line address |
| mem_wdata | output | DATA_W | Writeback data |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
The hardest case to reach is both ports waiting on the other array in the same cycle. It needs a set in which an instruction line sits in the data-side way and a data line sits in the instruction-side way. The bench builds that layout from reset. A data miss fills way 0, because every LRU bit starts at 0, and an instruction miss to the same set then fills way 1. The bench then presents both requests in the same cycle and measures each acknowledge latency. Two pseudo-random sweeps follow, one over a narrow tag range that forces eviction and writeback, and one over the whole address space. A bench model of a two-way LRU cache predicts the hit class, fills, writebacks and data of every access.

// File: rtl/semi_unified_cache.sv
module semi_unified_cache #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_req,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_ack,
  output logic [DATA_W-1:0] if_rdata,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic              d_ack,
  output logic [DATA_W-1:0] d_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;

  logic [1:0][SETS-1:0] vld, drt;
  logic [SETS-1:0]      lru;
  logic [TAG_W-1:0]     tg  [2][SETS];
  logic [DATA_W-1:0]    dat [2][SETS];

  st_t              st;
  logic             own_d, f_way;
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  logic             i_pend, d_pend;

  wire [IDX_W-1:0] ii = if_addr[IDX_W-1:0];
  wire [TAG_W-1:0] it = if_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] di = d_addr[IDX_W-1:0];
  wire [TAG_W-1:0] dt = d_addr[ADDR_W-1:IDX_W];

  wire i_m0 = vld[0][ii] && tg[0][ii] == it;
  wire i_m1 = vld[1][ii] && tg[1][ii] == it;
  wire d_m0 = vld[0][di] && tg[0][di] == dt;
  wire d_m1 = vld[1][di] && tg[1][di] == dt;

  wire busy  = st != S_IDLE;
  wire i_own = busy && !own_d;
  wire d_own = busy && own_d;
  wire i_blk = busy && ii == f_idx;
  wire d_blk = busy && di == f_idx;

  wire i_look = if_req && !i_pend && !i_blk;
  wire d_look = d_req && !d_pend && !d_blk;
  wire i_phit = i_look && i_m0;
  wire d_phit = d_look && d_m1;

  wire d_try  = d_pend && !d_own && !d_blk;
  wire d_shit = d_try && d_m0;
  wire d_miss = d_try && !d_m0;
  wire i_try  = i_pend && !i_own && !i_blk && !d_try;
  wire i_shit = i_try && i_m1;
  wire i_miss = i_try && !i_m1;

  wire start     = !busy && (d_miss || i_miss);
  wire [IDX_W-1:0] s_idx = d_miss ? di : ii;
  wire [TAG_W-1:0] s_tag = d_miss ? dt : it;
  wire fill_done = st == S_FILL && mem_ack;

  assign if_ack   = i_phit || i_shit;
  assign if_rdata = i_phit ? dat[0][ii] : dat[1][ii];
  assign d_ack    = d_phit || d_shit;
  assign d_rdata  = d_phit ? dat[1][di] : dat[0][di];

  assign mem_req   = busy;
  assign mem_we    = st == S_WB;
  assign mem_addr  = mem_we ? {tg[f_way][f_idx], f_idx} : {f_tag, f_idx};
  assign mem_wdata = dat[f_way][f_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      own_d  <= 1'b0;
      f_way  <= 1'b0;
      f_idx  <= '0;
      f_tag  <= '0;
      i_pend <= 1'b0;
      d_pend <= 1'b0;
      vld    <= '0;
      drt    <= '0;
      lru    <= '0;
    end else begin
      i_pend <= i_pend ? !(i_shit || (fill_done && !own_d)) : (i_look && !i_m0);
      d_pend <= d_pend ? !(d_shit || (fill_done && own_d)) : (d_look && !d_m1);

      case (st)
        S_IDLE: if (start) begin
          own_d <= d_miss;
          f_idx <= s_idx;
          f_tag <= s_tag;
          f_way <= lru[s_idx];
          st    <= (vld[lru[s_idx]][s_idx] && drt[lru[s_idx]][s_idx]) ? S_WB : S_FILL;
        end
        S_WB:   if (mem_ack) st <= S_FILL;
        default: if (mem_ack) st <= S_IDLE;
      endcase

      if (i_phit) lru[ii] <= 1'b1;
      if (i_shit) lru[ii] <= 1'b0;
      if (d_phit) lru[di] <= 1'b0;
      if (d_shit) lru[di] <= 1'b1;
      if (d_phit && d_we) drt[1][di] <= 1'b1;
      if (d_shit && d_we) drt[0][di] <= 1'b1;
      if (fill_done) begin
        lru[f_idx]        <= ~f_way;
        vld[f_way][f_idx] <= 1'b1;
        drt[f_way][f_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (d_phit && d_we) dat[1][di] <= d_wdata;
    if (d_shit && d_we) dat[0][di] <= d_wdata;
    if (fill_done) begin
      dat[f_way][f_idx] <= mem_rdata;
      tg[f_way][f_idx]  <= f_tag;
    end
  end
endmodule

// File: rtl/semi_unified_cache_check.sv
module semi_unified_cache_check #(
  parameter int ADDR_W = 6,
  parameter int SETS   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              if_ack,
  input logic              d_req,
  input logic              d_we,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              i_pend,
  input logic              d_pend,
  input logic              busy,
  input logic [2*SETS-1:0] dirty
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we); // R7
  AST_FILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !mem_req); // R9
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    i_pend && d_pend && !busy |-> !if_ack); // R4
  AST_NO_IFETCH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_req && d_we) |=> $countones(dirty) <= $countones($past(dirty))); // R8
endmodule

bind semi_unified_cache semi_unified_cache_check #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .if_ack(if_ack), .d_req(d_req), .d_we(d_we),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .i_pend(i_pend), .d_pend(d_pend), .busy(busy), .dirty(drt)
);

// File: tb/semi_unified_cache_tb.sv
module semi_unified_cache_tb;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic if_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
  logic [5:0] if_addr = '0, d_addr = '0;
  logic [31:0] d_wdata = '0;
  logic if_ack, d_ack, mem_req, mem_we;
  logic [31:0] if_rdata, d_rdata, mem_wdata;
  logic [5:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  semi_unified_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_rdata(if_rdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_ack(d_ack), .d_rdata(d_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  int fills = 0, wbs = 0, cnt = 0;
  logic [5:0]  wb_a, st_a;
  logic [31:0] wb_d;
  logic [31:0] mem [64];
  logic [31:0] gold [64];

  bit          mv [2][8];
  bit          md [2][8];
  logic [2:0]  mt [2][8];
  logic [31:0] mdat [2][8];
  bit          ml [8];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt <= 0;
    end else if (mem_req) begin
      if (cnt == 0) st_a <= mem_addr;
      if (cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        checks++;
        if (cnt != 0 && st_a != mem_addr) begin
          errors++;
          $display("FAIL R9 actual=%0h expected=%0h", mem_addr, st_a);
        end
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wbs++;
          wb_a <= mem_addr;
          wb_d <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr];
          fills++;
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic model(input bit pd, input bit we, input logic [5:0] a, input logic [31:0] wd,
                       output int cls, output bit ewb, output logic [5:0] ewa, output logic [31:0] ewd);
    int i, pw, hw;
    logic [2:0] t;
    i = int'(a[2:0]); t = a[5:3]; pw = pd ? 1 : 0;
    ewb = 1'b0; ewa = '0; ewd = '0;
    if (mv[pw][i] && mt[pw][i] == t) begin cls = 0; hw = pw; end
    else if (mv[1-pw][i] && mt[1-pw][i] == t) begin cls = 1; hw = 1 - pw; end
    else begin
      cls = 2; hw = ml[i] ? 1 : 0;
      ewb = mv[hw][i] && md[hw][i];
      ewa = {mt[hw][i], a[2:0]};
      ewd = mdat[hw][i];
      mv[hw][i] = 1'b1; mt[hw][i] = t; md[hw][i] = 1'b0; mdat[hw][i] = gold[a];
    end
    ml[i] = (hw == 0);
    if (we) begin
      mdat[hw][i] = wd; md[hw][i] = 1'b1; gold[a] = wd;
    end
  endtask

  task automatic acc(input bit pd, input bit we, input logic [5:0] a, input logic [31:0] wd);
    int cls, lat, f0, w0;
    bit ewb;
    logic [5:0] ewa;
    logic [31:0] ewd, exp, rd;
    exp = gold[a];
    model(pd, we, a, wd, cls, ewb, ewa, ewd);
    f0 = fills; w0 = wbs;
    @(negedge clk);
    if (pd) begin d_req = 1'b1; d_we = we; d_addr = a; d_wdata = wd; end
    else begin if_req = 1'b1; if_addr = a; end
    lat = 1;
    #1;
    while (!(pd ? d_ack : if_ack)) begin
      @(negedge clk); #1; lat++;
    end
    rd = pd ? d_rdata : if_rdata;
    @(negedge clk);
    if_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
    if (cls == 0) check(lat == 1, "R1 own-array hit latency", lat, 1);
    if (cls == 1) check(lat == 2 && fills == f0, "R2 other-array hit latency", lat, 2);
    if (cls == 2) check(lat > 2 && fills == f0 + 1, "R6 miss fill count", fills - f0, 1);
    check(wbs - w0 == int'(ewb), "R7/R8 writeback count", wbs - w0, ewb);
    if (ewb) check(wb_a == ewa && wb_d == ewd, "R7 writeback addr/data", {wb_a, wb_d[25:0]}, {ewa, ewd[25:0]});
    if (!we) check(rd == exp, "R11 read data", rd, exp);
    if (we && cls != 2) check(fills == f0 && wbs == w0, "R8 write hit no traffic", fills - f0 + wbs - w0, 0);
  endtask

  task automatic dual(input logic [5:0] ia, input logic [5:0] da, input int exp_li, input int exp_ld, input string req);
    int c, li, ld;
    logic [31:0] ri, rdd;
    li = 0; ld = 0; c = 1;
    @(negedge clk);
    if_req = 1'b1; if_addr = ia; d_req = 1'b1; d_we = 1'b0; d_addr = da;
    while (li == 0 || ld == 0) begin
      #1;
      if (li == 0 && if_ack) begin li = c; ri = if_rdata; end
      if (ld == 0 && d_ack) begin ld = c; rdd = d_rdata; end
      @(negedge clk);
      if (li != 0) if_req = 1'b0;
      if (ld != 0) d_req = 1'b0;
      c++;
    end
    check(li == exp_li, req, li, exp_li);
    check(ld == exp_ld, req, ld, exp_ld);
    check(ri == gold[ia] && rdd == gold[da], "R11 dual read data", ri, gold[ia]);
  endtask

  initial begin
    int cls;
    bit b;
    logic [5:0] xa;
    logic [31:0] xd;
    logic [15:0] r;
    for (int i = 0; i < 64; i++) begin
      mem[i] = (i * 32'h01010101) ^ 32'hA5A5_0000;
      gold[i] = mem[i];
    end
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 8; s++) begin mv[w][s] = 0; md[w][s] = 0; mt[w][s] = '0; mdat[w][s] = '0; end
    for (int s = 0; s < 8; s++) ml[s] = 0;
    repeat (4) @(posedge clk);
    #1;
    check(!if_ack && !d_ack && !mem_req, "R10 reset outputs idle", {if_ack, d_ack, mem_req}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R5: first fill of set 2 goes to the instruction-side way (LRU 0 after reset)
    acc(1, 0, 6'o12, 0);
    check(fills == 1, "R10 first access misses", fills, 1);
    acc(1, 0, 6'o12, 0);   // data now hits in way 0: partner hit (R5)
    acc(0, 0, 6'o32, 0);   // instruction miss fills way 1
    acc(0, 0, 6'o32, 0);   // partner hit again: R2 no refill
    // R4: both ports waiting on the other array together
    dual(6'o32, 6'o12, 3, 2, "R4 conflict latency");
    model(1, 0, 6'o12, 0, cls, b, xa, xd);
    model(0, 0, 6'o32, 0, cls, b, xa, xd);
    // R3: both ports hit their own array in one cycle
    acc(0, 0, 6'o05, 0);
    acc(1, 0, 6'o15, 0);
    dual(6'o05, 6'o15, 1, 1, "R3 parallel own hits");
    model(0, 0, 6'o05, 0, cls, b, xa, xd);
    model(1, 0, 6'o15, 0, cls, b, xa, xd);
    // R8: store then evict by pressure to force writebacks
    acc(1, 1, 6'o15, 32'hDEAD_0015);
    acc(1, 1, 6'o05, 32'hBEEF_0005);
    acc(0, 0, 6'o25, 0);
    acc(0, 0, 6'o35, 0);

    r = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      acc(r[0], r[0] & r[1] & ~r[2], {1'b0, r[4:3], r[7:5]}, {16'h5A00 ^ 16'(k), r});
    end
    for (int k = 0; k < 400; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      acc(r[1], r[1] & r[3], r[13:8], {r, 16'(k)});
    end

    // R7: memory holds latest value of every line not dirty in the cache
    for (int a = 0; a < 64; a++) begin
      b = 1'b0;
      for (int w = 0; w < 2; w++)
        if (mv[w][a % 8] && md[w][a % 8] && mt[w][a % 8] == 3'(a / 8)) b = 1'b1;
      if (!b) check(mem[a] == gold[a], "R7 memory contents", mem[a], gold[a]);
    end
    finish_run();
  end
endmodule